// File: doc/BRIEF.md
# Repeater Expansion Bus Port Controller

This block attaches one multiport repeater device to an expansion bus that several cascaded repeater devices share. From the device's per-port receive and collision activity and a flag that says the transmit FIFO is still draining, it raises an active-low request for the bus. Arbitration between devices happens outside the block and comes back only as an active-low acknowledge. The request and the acknowledge together select how the block uses the bus. It can sit idle with both lines released, drive the jam and data lines itself, or listen to a jam raised by another device.

The tri-state pads are not inferred here. The block presents a value and an output enable for each of the jam and data lines, and takes the pad values back as inputs. While jam is driven, the data line reports whether the local collision is single-port (high) or multiport (low). Otherwise it carries the repeated data bit. A jam and data pair received from another device passes through a two-flop synchronizer. It is then merged with local collision state into a collision flag and a collision-type flag for the rest of the repeater.

Top module: `xbus_port_ctrl`

## Requirements
- R1: `req_n` is low in the cycle after a clock edge that sampled any `port_rx` bit, any `port_col` bit or `fifo_busy` high, and high after an edge that sampled all of them low.
- R2: While `bus_ack_n` is high, `bus_jam_oe` and `bus_dat_oe` are both low and `bus_listen` is low.
- R3: While `bus_ack_n` is low and `req_n` is low, `bus_jam_oe` and `bus_dat_oe` are both high.
- R4: While `bus_ack_n` is low and `req_n` is high, `bus_listen` is high and both output enables are low.
- R5: `bus_jam_out` is high in the cycle after an edge that sampled at least one `port_col` bit high, and low otherwise.
- R6: When `bus_jam_out` is high, `bus_dat_out` is 1 (single-port) if the sampling edge saw exactly one `port_col` bit set and no `port_rx` bit set on any other port, and 0 (multiport) otherwise. When `bus_jam_out` is low, `bus_dat_out` equals `tx_data` sampled at the previous edge.
- R7: `jam_sync` and `dat_sync` equal `bus_jam_in` and `bus_dat_in` as sampled two edges earlier.
- R8: `col_seen` is high when `bus_jam_out` is high, or when `bus_listen` and `jam_sync` are both high.
- R9: `col_multi` is high when the local collision is multiport as defined in R6, or when `bus_listen` and `jam_sync` are high and either `dat_sync` is 0 or any local `port_rx`, `port_col` or `fifo_busy` input is currently high.
- R10: A clock edge with `rst` high returns `req_n` to 1 and clears `bus_jam_out`, `bus_dat_out`, `jam_sync`, `dat_sync`, `col_seen` and `col_multi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_rx | input | NPORTS | Per-port receive activity |
| port_col | input | NPORTS | Per-port collision activity |
| fifo_busy | input | 1 | Transmit FIFO still draining |
| tx_data | input | 1 | Repeated data bit to place on the data line |
| bus_ack_n | input | 1 | Bus acknowledge from the arbiter, active low |
| bus_jam_in | input | 1 | Jam pad value read back |
| bus_dat_in | input | 1 | Data pad value read back |
| req_n | output | 1 | Bus request, active low |
| bus_jam_out | output | 1 | Value for the jam pad |
| bus_jam_oe | output | 1 | Output enable for the jam pad |
| bus_dat_out | output | 1 | Value for the data pad |
| bus_dat_oe | output | 1 | Output enable for the data pad |
| bus_listen | output | 1 | Jam line is taken as an input from another device |
| jam_sync | output | 1 | Synchronized received jam |
| dat_sync | output | 1 | Synchronized received data |
| col_seen | output | 1 | Collision present, local or remote |
| col_multi | output | 1 | Collision classified as multiport |

## Verification
A stale or wrong request register shows up at once as swapped pad enables. Two devices would drive the bus together, or none would. A bad collision count or a bad other-port receive mask flips `bus_dat_out` one cycle after the offending inputs, and it does so only while jam is high. The stimulus therefore holds single, double and collision-plus-receive patterns long enough to compare every cycle. A synchronizer with the wrong depth shifts `jam_sync` by a cycle, and in listen mode that carries directly into `col_seen` and `col_multi`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_DRIVE  = 2'd1,
        MODE_LISTEN = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic active;
        logic col;
        logic single;
        logic multi;
        logic data;
    } loc_stat_t;

    localparam int unsigned MAX_PORTS = 64;

    function automatic logic [6:0] ones64(input logic [63:0] v);
        logic [6:0] n;
        n = '0;
        for (int i = 0; i < 64; i++) begin
            n = n + {6'd0, v[i]};
        end
        return n;
    endfunction

    function automatic bus_mode_e decode_mode(input logic ack_n, input logic req_n);
        if (ack_n)
            return MODE_IDLE;
        else if (!req_n)
            return MODE_DRIVE;
        else
            return MODE_LISTEN;
    endfunction

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xbus_activity.sv
module xbus_activity
    import xbus_pkg::*;
#(
    parameter int unsigned NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] port_rx,
    input  logic [NPORTS-1:0] port_col,
    input  logic              fifo_busy,
    input  logic              tx_data,
    output logic              active_now,
    output loc_stat_t         stat_q
);
    localparam int unsigned CW = 7;

    logic [63:0]   col_wide;
    logic [CW-1:0] col_cnt;
    logic          rx_elsewhere;
    loc_stat_t     stat_d;

    assign col_wide     = 64'(port_col);
    assign col_cnt      = ones64(col_wide);
    assign rx_elsewhere = |(port_rx & ~port_col);
    assign active_now   = (|port_rx) | (|port_col) | fifo_busy;

    always_comb begin
        stat_d        = '0;
        stat_d.active = active_now;
        stat_d.col    = (col_cnt != '0);
        stat_d.single = (col_cnt == CW'(1)) && !rx_elsewhere;
        stat_d.multi  = (col_cnt > CW'(1)) || ((col_cnt == CW'(1)) && rx_elsewhere);
        stat_d.data   = tx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/xbus_dir_ctrl.sv
module xbus_dir_ctrl
    import xbus_pkg::*;
(
    input  logic      ack_n,
    input  logic      req_n,
    input  loc_stat_t stat_q,
    output bus_mode_e mode,
    output logic      jam_out,
    output logic      jam_oe,
    output logic      dat_out,
    output logic      dat_oe
);
    assign mode    = decode_mode(ack_n, req_n);
    assign jam_oe  = (mode == MODE_DRIVE);
    assign dat_oe  = (mode == MODE_DRIVE);
    assign jam_out = stat_q.col;
    assign dat_out = stat_q.col ? stat_q.single : stat_q.data;
endmodule

// File: rtl/xbus_port_ctrl.sv
module xbus_port_ctrl
    import xbus_pkg::*;
#(
    parameter int unsigned NPORTS      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] port_rx,
    input  logic [NPORTS-1:0] port_col,
    input  logic              fifo_busy,
    input  logic              tx_data,
    input  logic              bus_ack_n,
    input  logic              bus_jam_in,
    input  logic              bus_dat_in,
    output logic              req_n,
    output logic              bus_jam_out,
    output logic              bus_jam_oe,
    output logic              bus_dat_out,
    output logic              bus_dat_oe,
    output logic              bus_listen,
    output logic              jam_sync,
    output logic              dat_sync,
    output logic              col_seen,
    output logic              col_multi
);
    localparam int unsigned SYNC_W = 2;

    loc_stat_t         stat_q;
    logic              active_now;
    bus_mode_e         mode;
    logic [SYNC_W-1:0] pad_raw;
    logic [SYNC_W-1:0] pad_sync;
    logic              remote_jam;

    xbus_activity #(.NPORTS(NPORTS)) u_activity (
        .clk        (clk),
        .rst        (rst),
        .port_rx    (port_rx),
        .port_col   (port_col),
        .fifo_busy  (fifo_busy),
        .tx_data    (tx_data),
        .active_now (active_now),
        .stat_q     (stat_q)
    );

    assign req_n = !stat_q.active;

    xbus_dir_ctrl u_dir (
        .ack_n   (bus_ack_n),
        .req_n   (req_n),
        .stat_q  (stat_q),
        .mode    (mode),
        .jam_out (bus_jam_out),
        .jam_oe  (bus_jam_oe),
        .dat_out (bus_dat_out),
        .dat_oe  (bus_dat_oe)
    );

    assign pad_raw = {bus_jam_in, bus_dat_in};

    xbus_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_raw),
        .q   (pad_sync)
    );

    assign jam_sync   = pad_sync[1];
    assign dat_sync   = pad_sync[0];
    assign bus_listen = (mode == MODE_LISTEN);
    assign remote_jam = bus_listen && jam_sync;
    assign col_seen   = stat_q.col || remote_jam;
    assign col_multi  = stat_q.multi || (remote_jam && (!dat_sync || active_now));
endmodule

// File: rtl/xbus_port_ctrl_chk.sv
module xbus_port_ctrl_chk #(
    parameter int unsigned NPORTS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORTS-1:0] port_rx,
    input logic [NPORTS-1:0] port_col,
    input logic              fifo_busy,
    input logic              bus_ack_n,
    input logic              bus_jam_in,
    input logic              req_n,
    input logic              bus_jam_out,
    input logic              bus_jam_oe,
    input logic              bus_dat_out,
    input logic              bus_dat_oe,
    input logic              bus_listen,
    input logic              jam_sync,
    input logic              col_seen,
    input logic              col_multi
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_req_on_R1: assert property (@(posedge clk) disable iff (rst)
        ((|port_rx) || (|port_col) || fifo_busy) |=> !req_n);
    assert_req_off_R1: assert property (@(posedge clk) disable iff (rst)
        (!(|port_rx) && !(|port_col) && !fifo_busy) |=> req_n);
    assert_released_R2: assert property (@(posedge clk) disable iff (rst)
        bus_ack_n |-> (!bus_jam_oe && !bus_dat_oe && !bus_listen));
    assert_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack_n && !req_n) |-> (bus_jam_oe && bus_dat_oe));
    assert_listen_R4: assert property (@(posedge clk) disable iff (rst)
        bus_listen |-> (!bus_jam_oe && !bus_dat_oe && req_n));
    assert_jam_R5: assert property (@(posedge clk) disable iff (rst)
        (|port_col) |=> bus_jam_out);
    assert_dat_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_jam_out && !bus_dat_out) |-> col_multi);
    assert_sync_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (jam_sync == $past(bus_jam_in, 2)));
    assert_seen_R8: assert property (@(posedge clk) disable iff (rst)
        bus_jam_out |-> col_seen);
    assert_multi_R9: assert property (@(posedge clk) disable iff (rst)
        col_multi |-> col_seen);
endmodule

bind xbus_port_ctrl xbus_port_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .port_rx     (port_rx),
    .port_col    (port_col),
    .fifo_busy   (fifo_busy),
    .bus_ack_n   (bus_ack_n),
    .bus_jam_in  (bus_jam_in),
    .req_n       (req_n),
    .bus_jam_out (bus_jam_out),
    .bus_jam_oe  (bus_jam_oe),
    .bus_dat_out (bus_dat_out),
    .bus_dat_oe  (bus_dat_oe),
    .bus_listen  (bus_listen),
    .jam_sync    (jam_sync),
    .col_seen    (col_seen),
    .col_multi   (col_multi)
);

// File: tb/xbus_port_ctrl_bench.sv
module xbus_port_ctrl_bench;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] port_rx, port_col;
    logic          fifo_busy, tx_data, bus_ack_n, bus_jam_in, bus_dat_in;
    logic          req_n, bus_jam_out, bus_jam_oe, bus_dat_out, bus_dat_oe;
    logic          bus_listen, jam_sync, dat_sync, col_seen, col_multi;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    xbus_port_ctrl #(.NPORTS(NP)) u_xbus_port_ctrl (
        .clk(clk), .rst(rst), .port_rx(port_rx), .port_col(port_col),
        .fifo_busy(fifo_busy), .tx_data(tx_data), .bus_ack_n(bus_ack_n),
        .bus_jam_in(bus_jam_in), .bus_dat_in(bus_dat_in), .req_n(req_n),
        .bus_jam_out(bus_jam_out), .bus_jam_oe(bus_jam_oe),
        .bus_dat_out(bus_dat_out), .bus_dat_oe(bus_dat_oe),
        .bus_listen(bus_listen), .jam_sync(jam_sync), .dat_sync(dat_sync),
        .col_seen(col_seen), .col_multi(col_multi)
    );

    // behavioural reference state
    bit m_act, m_col, m_single, m_multi, m_data;
    bit m_j1, m_j2, m_d1, m_d2;

    always @(posedge clk) begin
        int ncol;
        bit other_rx;
        ncol = 0;
        other_rx = 0;
        for (int i = 0; i < NP; i++) begin
            if (port_col[i]) ncol++;
            else if (port_rx[i]) other_rx = 1;
        end
        if (rst) begin
            m_act <= 0; m_col <= 0; m_single <= 0; m_multi <= 0; m_data <= 0;
            m_j1 <= 0; m_j2 <= 0; m_d1 <= 0; m_d2 <= 0;
        end else begin
            m_act    <= (port_rx != 0) || (port_col != 0) || fifo_busy;
            m_col    <= ncol > 0;
            m_single <= (ncol == 1) && !other_rx;
            m_multi  <= (ncol >= 2) || (ncol == 1 && other_rx);
            m_data   <= tx_data;
            m_j1 <= bus_jam_in; m_j2 <= m_j1;
            m_d1 <= bus_dat_in; m_d2 <= m_d1;
        end
        cyc++;
    end

    task automatic chk(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        bit listen, drive, rem, now;
        listen = !bus_ack_n && !m_act;
        drive  = !bus_ack_n && m_act;
        rem    = listen && m_j2;
        now    = (port_rx != 0) || (port_col != 0) || fifo_busy;
        chk("R1 req_n", req_n, !m_act);
        chk("R2/R3/R4 jam_oe", bus_jam_oe, drive);
        chk("R2/R3/R4 dat_oe", bus_dat_oe, drive);
        chk("R4 listen", bus_listen, listen);
        chk("R5 jam_out", bus_jam_out, m_col);
        chk("R6 dat_out", bus_dat_out, m_col ? m_single : m_data);
        chk("R7 jam_sync", jam_sync, m_j2);
        chk("R7 dat_sync", dat_sync, m_d2);
        chk("R8 col_seen", col_seen, m_col || rem);
        chk("R9 col_multi", col_multi, m_multi || (rem && (!m_d2 || now)));
    endtask

    function automatic logic [NP-1:0] onehot(input int idx);
        return NP'(1) << (idx % NP);
    endfunction

    task automatic drive_in(input int c);
        int ph;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ph = c / 100;
        port_rx = '0; port_col = '0; fifo_busy = 0;
        tx_data = lfsr[3];
        bus_ack_n = lfsr[5];
        bus_jam_in = lfsr[7];
        bus_dat_in = lfsr[9];
        case (ph)
            0: ;                                                   // idle, R2 and R4
            1: port_rx = onehot(int'(lfsr[14:12]));                // R1 receive only
            2: begin port_col = onehot(c); port_rx = lfsr[2] ? port_col : '0; end // R6 single
            3: port_col = onehot(c) | onehot(c + 3);               // R6 multiport
            4: begin port_col = onehot(c); port_rx = onehot(c + 1); end // R6 col plus rx elsewhere
            5: begin fifo_busy = lfsr[4]; bus_ack_n = 0; end       // R1, R3, R4 fifo drain
            6: bus_ack_n = lfsr[5] & lfsr[6];                      // R8 remote jam in listen
            7: begin bus_ack_n = 0; fifo_busy = lfsr[10] & lfsr[11]; end // R9 local activity during listen
            default: begin
                port_rx   = lfsr[17:10] & lfsr[25:18];
                port_col  = lfsr[16] ? (lfsr[27:20] & lfsr[31:24]) : '0;
                fifo_busy = lfsr[8];
            end
        endcase
    endtask

    initial begin
        rst = 1;
        port_rx = '0; port_col = '0; fifo_busy = 0; tx_data = 1;
        bus_ack_n = 0; bus_jam_in = 1; bus_dat_in = 1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 req_n", req_n, 1'b1);
        chk("R10 jam_out", bus_jam_out, 1'b0);
        chk("R10 dat_out", bus_dat_out, 1'b0);
        chk("R10 jam_sync", jam_sync, 1'b0);
        chk("R10 dat_sync", dat_sync, 1'b0);
        chk("R10 col_seen", col_seen, 1'b0);
        chk("R10 col_multi", col_multi, 1'b0);
        rst = 0;
        for (int c = 0; c < 1500; c++) begin
            drive_in(c);
            @(negedge clk);
            compare_all();
            if (c == 1200) begin
                rst = 1;
                port_col = '1; fifo_busy = 1; bus_jam_in = 1; bus_dat_in = 1;
                @(negedge clk);
                chk("R10 mid-run req_n", req_n, 1'b1);
                chk("R10 mid-run jam_out", bus_jam_out, 1'b0);
                chk("R10 mid-run col_multi", col_multi, 1'b0);
                rst = 0;
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule